// File: doc/BRIEF.md
# SIMT Branch Divergence and Reconvergence Stack

This block tracks control flow for one warp of four threads that share a single instruction stream on SIMD hardware. It holds a small stack of entries, each recording where a group of threads goes next, the point at which that group merges back with its siblings, and which threads belong to the group. The entry on top always names the instruction address to fetch next and the lanes that may execute it.

Each time the warp issues an instruction, the block is told whether it was a conditional branch. For a branch it also gets the per-thread taken vector, the branch destination, the address after the branch and the merge address. When every live thread goes the same way, only the top address moves. When the live threads split, the top entry is parked at the merge address with its full mask, and one entry per path is stacked. The taken path goes on top so it runs first. When a path's next address reaches its merge address, that entry is removed and the group below resumes. An empty path, where the destination already equals the merge address, is not stacked. A split whose merge address matches that of the current group replaces the current entry instead of parking it. A split that would exceed the stack capacity is refused, and a sticky error is raised.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the fetch address is RESET_PC, the fetch mask is all ones (1111), the depth is 1 and the overflow flag is 0.
- R2: A non-branch step advances the top fetch address by exactly 1 and keeps the fetch mask.
- R3: A branch whose taken vector, ANDed with the fetch mask, equals the fetch mask moves the top to the destination address. If that AND is zero, the top moves to the fall-through address. In both cases depth does not grow. Taken bits outside the fetch mask are ignored.
- R4: A branch that splits the live lanes adds two entries (depth +2). The next fetch is the destination address with mask = taken AND live.
- R5: When the taken path's next address reaches its merge address, its entry is removed. Fetch continues at the fall-through address with mask = live AND NOT taken.
- R6: When the second path reaches the merge address, its entry is removed. Fetch resumes at the merge address with the full mask that was live before the split.
- R7: A path whose start address equals the merge address is not stacked. If only the fall-through address equals it, the split adds one entry.
- R8: If a split's merge address equals the merge address of the current non-bottom top entry, that entry is replaced by the paths rather than parked. A two-path split then changes depth by +1.
- R9: A split that would make the depth exceed DEPTH leaves the fetch address, mask and depth unchanged and sets the overflow flag, which stays set until reset.
- R10: The bottom entry is never removed, whatever address it reaches, including address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| step_valid | input | 1 | The warp issued the instruction at fetch_pc this cycle |
| step_is_branch | input | 1 | The issued instruction is a conditional branch |
| br_taken_mask | input | LANES | Per-lane branch outcome, 1 = taken |
| br_target_pc | input | PC_W | Destination address of the taken path |
| br_fallthru_pc | input | PC_W | Address following the branch |
| br_reconv_pc | input | PC_W | Address where both paths merge |
| fetch_pc | output | PC_W | Next address for the warp (top entry) |
| fetch_mask | output | LANES | Lanes enabled for that address |
| stack_depth | output | CNT_W | Number of valid entries, 1 to DEPTH |
| overflow_err | output | 1 | Sticky flag: a split was refused for lack of space |

## Verification
Branches are applied with taken vectors that are all-live, empty, partially live with out-of-mask bits set, and truly split. This separates uniform moves from pushes and shows that out-of-mask bits have no effect. Split sequences are run with both paths non-empty, with an empty fall-through path, and with an inner split sharing the outer merge address. These show the pop order, the mask restored at each merge, and top replacement against parking. A bench instance with a shallow stack drives a nested split past capacity to expose the refused push and the sticky flag. A step that takes the bottom entry to address 0 shows that the bottom is never removed.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;
   typedef enum logic [1:0] {
      STEP_SEQ = 2'd0,
      STEP_UNI = 2'd1,
      STEP_DIV = 2'd2
   } step_kind_e;
endpackage

// File: rtl/simt_branch_classify.sv
module simt_branch_classify
   import simt_stack_pkg::*;
#(
   parameter int LANES = 4,
   parameter int PC_W  = 16
) (
   input  logic             is_branch,
   input  logic [LANES-1:0] live_mask,
   input  logic [LANES-1:0] taken_mask,
   input  logic [PC_W-1:0]  cur_pc,
   input  logic [PC_W-1:0]  target_pc,
   input  logic [PC_W-1:0]  fallthru_pc,
   output step_kind_e       kind,
   output logic [LANES-1:0] tk_mask,
   output logic [LANES-1:0] nt_mask,
   output logic [PC_W-1:0]  next_pc
);
   always_comb begin
      tk_mask = taken_mask & live_mask;
      nt_mask = live_mask & ~taken_mask;
      if (!is_branch) begin
         kind    = STEP_SEQ;
         next_pc = cur_pc + PC_W'(1);
      end else if (tk_mask == '0) begin
         kind    = STEP_UNI;
         next_pc = fallthru_pc;
      end else if (nt_mask == '0) begin
         kind    = STEP_UNI;
         next_pc = target_pc;
      end else begin
         kind    = STEP_DIV;
         next_pc = cur_pc;
      end
   end
endmodule

// File: rtl/simt_stack_store.sv
module simt_stack_store #(
   parameter int              LANES    = 4,
   parameter int              PC_W     = 16,
   parameter int              DEPTH    = 8,
   parameter logic [PC_W-1:0] RESET_PC = '0,
   localparam int             IDX_W    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [PC_W-1:0]  rd_pc,
   output logic [PC_W-1:0]  rd_rpc,
   output logic [LANES-1:0] rd_mask,
   input  logic             top_we,
   input  logic [IDX_W-1:0] top_idx,
   input  logic [PC_W-1:0]  top_pc,
   input  logic             a_we,
   input  logic [IDX_W-1:0] a_idx,
   input  logic [PC_W-1:0]  a_pc,
   input  logic [PC_W-1:0]  a_rpc,
   input  logic [LANES-1:0] a_mask,
   input  logic             b_we,
   input  logic [IDX_W-1:0] b_idx,
   input  logic [PC_W-1:0]  b_pc,
   input  logic [PC_W-1:0]  b_rpc,
   input  logic [LANES-1:0] b_mask
);
   logic [PC_W-1:0]  pc_q   [DEPTH];
   logic [PC_W-1:0]  rpc_q  [DEPTH];
   logic [LANES-1:0] mask_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      localparam logic [PC_W-1:0]  INIT_PC   = (g == 0) ? RESET_PC : '0;
      localparam logic [LANES-1:0] INIT_MASK = (g == 0) ? '1 : '0;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pc_q[g]   <= INIT_PC;
            rpc_q[g]  <= '0;
            mask_q[g] <= INIT_MASK;
         end else if (b_we && b_idx == IDX_W'(g)) begin
            pc_q[g]   <= b_pc;
            rpc_q[g]  <= b_rpc;
            mask_q[g] <= b_mask;
         end else if (a_we && a_idx == IDX_W'(g)) begin
            pc_q[g]   <= a_pc;
            rpc_q[g]  <= a_rpc;
            mask_q[g] <= a_mask;
         end else if (top_we && top_idx == IDX_W'(g)) begin
            pc_q[g]   <= top_pc;
         end
      end
   end

   assign rd_pc   = pc_q[rd_idx];
   assign rd_rpc  = rpc_q[rd_idx];
   assign rd_mask = mask_q[rd_idx];
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
   import simt_stack_pkg::*;
#(
   parameter int              LANES    = 4,
   parameter int              PC_W     = 16,
   parameter int              DEPTH    = 8,
   parameter logic [PC_W-1:0] RESET_PC = 16'h0100,
   localparam int             CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_valid,
   input  logic             step_is_branch,
   input  logic [LANES-1:0] br_taken_mask,
   input  logic [PC_W-1:0]  br_target_pc,
   input  logic [PC_W-1:0]  br_fallthru_pc,
   input  logic [PC_W-1:0]  br_reconv_pc,
   output logic [PC_W-1:0]  fetch_pc,
   output logic [LANES-1:0] fetch_mask,
   output logic [CNT_W-1:0] stack_depth,
   output logic             overflow_err
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int SUM_W = CNT_W + 1;

   initial begin
      AST_PARAM_DEPTH : assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      AST_PARAM_LANES : assert (LANES >= 2) else $error("LANES must be at least 2");
      AST_PARAM_PCW   : assert (PC_W >= 2)  else $error("PC_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic [IDX_W-1:0] top_idx;
   logic [PC_W-1:0]  top_pc, top_rpc;
   logic [LANES-1:0] top_mask;
   logic             at_bottom;

   step_kind_e       kind;
   logic [LANES-1:0] tk_mask, nt_mask;
   logic [PC_W-1:0]  next_pc;

   assign top_idx   = IDX_W'(cnt_q - CNT_W'(1));
   assign at_bottom = (cnt_q == CNT_W'(1));

   simt_branch_classify #(.LANES(LANES), .PC_W(PC_W)) classify_i (
      .is_branch   (step_is_branch),
      .live_mask   (top_mask),
      .taken_mask  (br_taken_mask),
      .cur_pc      (top_pc),
      .target_pc   (br_target_pc),
      .fallthru_pc (br_fallthru_pc),
      .kind        (kind),
      .tk_mask     (tk_mask),
      .nt_mask     (nt_mask),
      .next_pc     (next_pc)
   );

   // Sequencing decisions
   logic             div_fire, do_div, pop, merge_top, push_nt, push_tk, ovf_hit;
   logic [SUM_W-1:0] base, new_cnt;

   assign div_fire  = step_valid && (kind == STEP_DIV);
   assign pop       = step_valid && (kind != STEP_DIV) && !at_bottom && (next_pc == top_rpc);
   assign merge_top = !at_bottom && (br_reconv_pc == top_rpc);
   assign push_nt   = (br_fallthru_pc != br_reconv_pc);
   assign push_tk   = (br_target_pc != br_reconv_pc);
   assign base      = merge_top ? SUM_W'(cnt_q) - SUM_W'(1) : SUM_W'(cnt_q);
   assign new_cnt   = base + SUM_W'(push_nt) + SUM_W'(push_tk);
   assign ovf_hit   = div_fire && (new_cnt > SUM_W'(DEPTH));
   assign do_div    = div_fire && !ovf_hit;

   // Storage write ports
   logic             top_we, a_we, b_we;
   logic [PC_W-1:0]  top_wpc, a_pc;
   logic [LANES-1:0] a_mask;
   logic [IDX_W-1:0] a_idx, b_idx;

   assign top_we  = (step_valid && (kind != STEP_DIV) && !pop) || (do_div && !merge_top);
   assign top_wpc = (kind == STEP_DIV) ? br_reconv_pc : next_pc;
   assign a_we    = do_div && (push_nt || push_tk);
   assign a_idx   = IDX_W'(base);
   assign a_pc    = push_nt ? br_fallthru_pc : br_target_pc;
   assign a_mask  = push_nt ? nt_mask : tk_mask;
   assign b_we    = do_div && push_nt && push_tk;
   assign b_idx   = IDX_W'(base + SUM_W'(1));

   simt_stack_store #(
      .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .RESET_PC(RESET_PC)
   ) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (top_idx),
      .rd_pc   (top_pc),
      .rd_rpc  (top_rpc),
      .rd_mask (top_mask),
      .top_we  (top_we),
      .top_idx (top_idx),
      .top_pc  (top_wpc),
      .a_we    (a_we),
      .a_idx   (a_idx),
      .a_pc    (a_pc),
      .a_rpc   (br_reconv_pc),
      .a_mask  (a_mask),
      .b_we    (b_we),
      .b_idx   (b_idx),
      .b_pc    (br_target_pc),
      .b_rpc   (br_reconv_pc),
      .b_mask  (tk_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(1);
         ovf_q <= 1'b0;
      end else begin
         if (pop)         cnt_q <= cnt_q - CNT_W'(1);
         else if (do_div) cnt_q <= CNT_W'(new_cnt);
         if (ovf_hit)     ovf_q <= 1'b1;
      end
   end

   assign fetch_pc     = top_pc;
   assign fetch_mask   = top_mask;
   assign stack_depth  = cnt_q;
   assign overflow_err = ovf_q;

   // Checks
   AST_DEPTH_BOUND : assert property (@(posedge clk) disable iff (!rst_n)
      stack_depth >= CNT_W'(1) && stack_depth <= CNT_W'(DEPTH)); // R9
   AST_OVF_STICKY : assert property (@(posedge clk) disable iff (!rst_n)
      overflow_err |=> overflow_err); // R9
   AST_OVF_DROP : assert property (@(posedge clk) disable iff (!rst_n)
      ovf_hit |=> $stable(fetch_pc) && $stable(fetch_mask) && $stable(stack_depth)); // R9
   AST_MASK_LIVE : assert property (@(posedge clk) disable iff (!rst_n)
      fetch_mask != '0); // R4
   AST_BOTTOM_FULL : assert property (@(posedge clk) disable iff (!rst_n)
      stack_depth == CNT_W'(1) |-> fetch_mask == '1); // R10
   AST_UNIFORM_NOGROW : assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && kind != STEP_DIV) |=> stack_depth <= $past(stack_depth)); // R3
   AST_SPLIT_GROWS : assert property (@(posedge clk) disable iff (!rst_n)
      (do_div && push_nt && push_tk && !merge_top) |=> stack_depth == $past(stack_depth) + CNT_W'(2)); // R4
endmodule

// File: tb/simt_reconv_stack_tb_top.sv
`timescale 1ns/1ps
module simt_reconv_stack_tb_top;
   localparam int LANES = 4;
   localparam int PC_W  = 16;
   localparam int DEPTH = 4;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             step_valid = 1'b0;
   logic             step_is_branch = 1'b0;
   logic [LANES-1:0] br_taken_mask = '0;
   logic [PC_W-1:0]  br_target_pc = '0;
   logic [PC_W-1:0]  br_fallthru_pc = '0;
   logic [PC_W-1:0]  br_reconv_pc = '0;
   logic [PC_W-1:0]  fetch_pc;
   logic [LANES-1:0] fetch_mask;
   logic [CNT_W-1:0] stack_depth;
   logic             overflow_err;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   simt_reconv_stack #(
      .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .RESET_PC(16'h0100)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_is_branch(step_is_branch),
      .br_taken_mask(br_taken_mask), .br_target_pc(br_target_pc),
      .br_fallthru_pc(br_fallthru_pc), .br_reconv_pc(br_reconv_pc),
      .fetch_pc(fetch_pc), .fetch_mask(fetch_mask), .stack_depth(stack_depth),
      .overflow_err(overflow_err)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic expect_state(input string req, input int pc, input int mask, input int depth);
      chk(req, "fetch_pc", int'(fetch_pc), pc);
      chk(req, "fetch_mask", int'(fetch_mask), mask);
      chk(req, "stack_depth", int'(stack_depth), depth);
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic issue(input bit br, input int tmask, input int tgt, input int ft, input int rc);
      step_valid     = 1'b1;
      step_is_branch = br;
      br_taken_mask  = LANES'(tmask);
      br_target_pc   = PC_W'(tgt);
      br_fallthru_pc = PC_W'(ft);
      br_reconv_pc   = PC_W'(rc);
      @(negedge clk);
      step_valid     = 1'b0;
      step_is_branch = 1'b0;
   endtask

   task automatic t_reset();
      expect_state("R1", 'h100, 'hF, 1);
      chk("R1", "overflow_err", int'(overflow_err), 0);
   endtask

   task automatic t_sequential();
      issue(0, 0, 0, 0, 0);
      expect_state("R2", 'h101, 'hF, 1);
      issue(0, 0, 0, 0, 0);
      expect_state("R2", 'h102, 'hF, 1);
   endtask

   task automatic t_uniform_and_bottom();
      issue(1, 'hF, 'h000, 'h103, 'h150);
      expect_state("R10", 'h000, 'hF, 1);
      issue(1, 'hF, 'h200, 'h001, 'h150);
      expect_state("R3", 'h200, 'hF, 1);
      issue(1, 'h0, 'h250, 'h201, 'h260);
      expect_state("R3", 'h201, 'hF, 1);
   endtask

   task automatic t_two_path_split();
      issue(1, 'b0001, 'h300, 'h202, 'h400);
      expect_state("R4", 'h300, 'b0001, 3);
      issue(0, 0, 0, 0, 0);
      expect_state("R2", 'h301, 'b0001, 3);
      // all bits set but only lane 0 is live: uniform taken, reaching the merge point
      issue(1, 'hF, 'h400, 'h302, 'h500);
      expect_state("R5", 'h202, 'b1110, 2);
      issue(0, 0, 0, 0, 0);
      expect_state("R2", 'h203, 'b1110, 2);
      // lane 0 bit is outside the live mask: uniform not taken
      issue(1, 'b0001, 'h380, 'h400, 'h500);
      expect_state("R6", 'h400, 'hF, 1);
   endtask

   task automatic t_empty_path();
      issue(1, 'b0110, 'h500, 'h600, 'h600);
      expect_state("R7", 'h500, 'b0110, 2);
      issue(0, 0, 0, 0, 0);
      issue(1, 'b0110, 'h600, 'h502, 'h700);
      expect_state("R7", 'h600, 'hF, 1);
   endtask

   task automatic t_shared_merge();
      issue(1, 'b0011, 'h700, 'h601, 'h800);
      expect_state("R4", 'h700, 'b0011, 3);
      issue(1, 'b0001, 'h710, 'h701, 'h800);
      expect_state("R8", 'h710, 'b0001, 4);
      issue(1, 'b0000, 'h720, 'h800, 'h900);
      expect_state("R8", 'h701, 'b0010, 3);
      issue(1, 'b0010, 'h800, 'h702, 'h900);
      expect_state("R8", 'h601, 'b1100, 2);
      issue(1, 'b0000, 'h610, 'h800, 'h900);
      expect_state("R6", 'h800, 'hF, 1);
   endtask

   task automatic t_overflow();
      issue(1, 'b0111, 'h900, 'h801, 'hA00);
      expect_state("R4", 'h900, 'b0111, 3);
      chk("R9", "overflow_err before", int'(overflow_err), 0);
      issue(1, 'b0011, 'h910, 'h901, 'h980);
      expect_state("R9", 'h900, 'b0111, 3);
      chk("R9", "overflow_err set", int'(overflow_err), 1);
      issue(0, 0, 0, 0, 0);
      expect_state("R9", 'h901, 'b0111, 3);
      chk("R9", "overflow_err sticky", int'(overflow_err), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sequential();
      t_uniform_and_bottom();
      t_two_path_split();
      t_empty_path();
      t_shared_merge();
      t_overflow();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule